// File: doc/BRIEF.md
# Divider Configuration Front End

This block sits between the configuration pins of a programmable clock synthesizer and its divider logic. It resolves three values: a 9-bit feedback divide ratio, a 3-bit output divide code and a 2-bit test selector. The divide values can come from a parallel pin group, which is qualified by an active-low strobe. They can also come from a three-wire serial port made of a data pin, a shift clock and a load strobe. Whichever path loaded last is the one in force.

The serial load strobe works like a transparent latch around the shift register. Raising it moves the shift register contents to the outputs. While it stays high, every new shift shows up on the outputs at once. Lowering it freezes the value. A test pin is driven from one of four sources, chosen by the test selector, and is held low while the parallel strobe is low. A master reset input asserts the divider reset without erasing any loaded value. A status flag reports whether the feedback ratio lies inside the lock window.

All pins are sampled in a fast system clock through two-flop synchronizers, so every pin level must be held for several system clocks. The divider-output and synthesized-clock inputs of the test multiplexer are passed through without sampling.

Top module: `divcfg_loader`

## Requirements
- R1: While `pld_n` is low, `m_out` and `n_out` follow `pm_in` and `pn_in`, with at most a few system clocks of delay.
- R2: After `pld_n` rises, `m_out` and `n_out` keep the last pin values seen while it was low, even when `pm_in`/`pn_in` change later, until `pld_n` goes low again or a serial load takes place.
- R3: The shift register takes in `sdat` on each rising edge of `sclk`, but only while `pld_n` is high. The word is 14 bits, sent MSB first in the order T1, T0, N2..N0, M8..M0. After 14 clocks the word holds T in bits [13:12], N in bits [11:9] and M in bits [8:0].
- R4: A rising `sld` (with `pld_n` high) moves the shift register fields to `m_out`, `n_out` and the test selector. After `sld` falls, later shifts do not change the outputs.
- R5: While `sld` stays high (with `pld_n` high), each rising `sclk` edge makes the updated shift register contents appear on the outputs.
- R6: The test selector T is loaded only by the serial path. With `pld_n` high it drives `test_out` as follows: 00 gives low, 01 gives the serial data input, 10 gives `mfb_in`, 11 gives `fout_in`.
- R7: `test_out` is low whenever `pld_n` is low, whatever T holds.
- R8: A high `mrst` drives `div_rst` high. `mrst` leaves `m_out`, `n_out` and T unchanged.
- R9: `m_ok` is high exactly when `m_out` lies between 250 and 500 inclusive. A feedback ratio outside that range is still passed to `m_out` unchanged.
- R10: After `rst_n` is released, `m_out` is 250, `n_out` is 000 and T is 00.
- R11: Lowering `pld_n` after a serial load hands control back to the parallel pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Power-up reset, active low |
| pld_n | input | 1 | Parallel load strobe, active low |
| pm_in | input | 9 | Parallel feedback ratio pins |
| pn_in | input | 3 | Parallel output divide code pins |
| sclk | input | 1 | Serial shift clock |
| sdat | input | 1 | Serial data |
| sld | input | 1 | Serial load strobe |
| mrst | input | 1 | Master reset request |
| mfb_in | input | 1 | Feedback divider output, used as a test source |
| fout_in | input | 1 | Synthesized clock, used as a test source |
| m_out | output | 9 | Resolved feedback divide ratio |
| n_out | output | 3 | Resolved output divide code |
| test_out | output | 1 | Test pin |
| div_rst | output | 1 | Divider reset / output disable |
| m_ok | output | 1 | Feedback ratio inside lock window |

## Verification
The hardest case to reach from the ports is the gap between the two serial behaviours: a shift clock that arrives after the load strobe has fallen must change the shift register but not the outputs. A later load pulse is the only way to reveal the shifted word. The bench therefore shifts a random word, pulses the strobe, then shifts more bits with the strobe low and checks that the outputs stay frozen. It then pulses again and checks that the model's shifted word appears. Shift clocks given while the parallel strobe is low are exposed the same way. Random parallel loads, frozen serial loads and transparent serial shifts are interleaved, and the 249/250/500/501 edges of the lock window are driven directly.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    TSEL_LOW  = 2'b00,
    TSEL_SDAT = 2'b01,
    TSEL_MFB  = 2'b10,
    TSEL_FOUT = 2'b11
  } tsel_e;

  // inclusive window test on zero-extended values
  function automatic logic in_window(input logic [15:0] v,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= RST_VAL;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic [WORD_W-1:0] sh_q,
  output logic [WORD_W-1:0] sh_next,
  output logic              shift_ev
);
  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign shift_ev = en && sclk_s && !sclk_d;
  assign sh_next  = shift_ev ? {sh_q[WORD_W-2:0], sdat_s} : sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_next;
  end

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sclk_s && !sclk_d) |=> (sh_q[0] == $past(sdat_s))); // R3
  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (sh_q == $past(sh_q))); // R3
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold #(
  parameter int           M_W   = 9,
  parameter int           N_W   = 3,
  parameter int           T_W   = 2,
  parameter logic [M_W-1:0] M_RST = 9'd250,
  localparam int          WORD_W = M_W + N_W + T_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pld_n_s,
  input  logic              sld_s,
  input  logic [M_W-1:0]    pm_s,
  input  logic [N_W-1:0]    pn_s,
  input  logic [WORD_W-1:0] sh_next,
  output logic [M_W-1:0]    m_q,
  output logic [N_W-1:0]    n_q,
  output logic [T_W-1:0]    t_q
);
  // parallel low: follow pins; serial strobe high: follow shift word;
  // otherwise hold (that is the latching on either rising strobe / falling sld)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_RST;
      n_q <= '0;
      t_q <= '0;
    end else if (!pld_n_s) begin
      m_q <= pm_s;
      n_q <= pn_s;
    end else if (sld_s) begin
      {t_q, n_q, m_q} <= sh_next;
    end
  end

  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pld_n_s) |=> (m_q == $past(pm_s) && n_q == $past(pn_s))); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_n_s && !sld_s) |=> ({t_q, n_q, m_q} == $past({t_q, n_q, m_q}))); // R2
  AST_SER_XPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_n_s && sld_s) |=> ({t_q, n_q, m_q} == $past(sh_next))); // R5
  AST_T_PAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pld_n_s) |=> (t_q == $past(t_q))); // R6
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
  parameter int M_W    = 9,
  parameter int N_W    = 3,
  parameter int T_W    = 2,
  parameter int STAGES = 2,
  parameter int M_LO   = 250,
  parameter int M_HI   = 500,
  parameter int M_DEF  = 250
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pld_n,
  input  logic [M_W-1:0] pm_in,
  input  logic [N_W-1:0] pn_in,
  input  logic           sclk,
  input  logic           sdat,
  input  logic           sld,
  input  logic           mrst,
  input  logic           mfb_in,
  input  logic           fout_in,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic           test_out,
  output logic           div_rst,
  output logic           m_ok
);
  import cfg_pkg::*;

  localparam int WORD_W = M_W + N_W + T_W;
  localparam int DATA_W = M_W + N_W;

  logic pld_n_s, sld_s, sclk_s, sdat_s, mrst_s;
  logic [M_W-1:0]    pm_s;
  logic [N_W-1:0]    pn_s;
  logic [WORD_W-1:0] sh_q, sh_next;
  logic              shift_ev;
  logic [T_W-1:0]    t_q;
  tsel_e             tsel;

  cfg_sync #(.W(5), .STAGES(STAGES), .RST_VAL(5'b10000)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pld_n, sld, sclk, sdat, mrst}),
    .q({pld_n_s, sld_s, sclk_s, sdat_s, mrst_s})
  );

  cfg_sync #(.W(DATA_W), .STAGES(STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pm_in, pn_in}),
    .q({pm_s, pn_s})
  );

  cfg_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(pld_n_s),
    .sclk_s(sclk_s), .sdat_s(sdat_s),
    .sh_q(sh_q), .sh_next(sh_next), .shift_ev(shift_ev)
  );

  cfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .M_RST(M_W'(M_DEF))) u_hold (
    .clk(clk), .rst_n(rst_n), .pld_n_s(pld_n_s), .sld_s(sld_s),
    .pm_s(pm_s), .pn_s(pn_s), .sh_next(sh_next),
    .m_q(m_out), .n_q(n_out), .t_q(t_q)
  );

  assign tsel = tsel_e'(t_q[1:0]);

  always_comb begin
    test_out = 1'b0;
    if (pld_n_s) begin
      unique case (tsel)
        TSEL_LOW:  test_out = 1'b0;
        TSEL_SDAT: test_out = sdat_s;
        TSEL_MFB:  test_out = mfb_in;
        TSEL_FOUT: test_out = fout_in;
      endcase
    end
  end

  assign div_rst = mrst_s;
  assign m_ok    = in_window(16'(m_out), 16'(M_LO), 16'(M_HI));

  AST_TEST_PAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pld_n_s) |-> (!test_out)); // R7
  AST_MRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst_s && pld_n_s && !sld_s) |=> (m_out == $past(m_out) && n_out == $past(n_out))); // R8
  AST_SHIFT_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !sld_s) |=> (m_out == $past(m_out))); // R4
  AST_SH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_ev) |=> (sh_q == $past(sh_q))); // R3
endmodule

// File: tb/divcfg_loader_tb.sv
module divcfg_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pld_n = 1'b1;
  logic [8:0] pm_in = '0;
  logic [2:0] pn_in = '0;
  logic       sclk = 1'b0, sdat = 1'b0, sld = 1'b0, mrst = 1'b0;
  logic       mfb_in = 1'b0, fout_in = 1'b0;
  logic [8:0] m_out;
  logic [2:0] n_out;
  logic       test_out, div_rst, m_ok;

  int total = 0;
  int bad = 0;
  logic [13:0] bsh = '0;
  logic [8:0]  bm = 9'd250;
  logic [2:0]  bn = '0;
  logic [1:0]  bt = '0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  divcfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .pld_n(pld_n), .pm_in(pm_in), .pn_in(pn_in),
    .sclk(sclk), .sdat(sdat), .sld(sld), .mrst(mrst),
    .mfb_in(mfb_in), .fout_in(fout_in),
    .m_out(m_out), .n_out(n_out), .test_out(test_out),
    .div_rst(div_rst), .m_ok(m_ok)
  );

  function automatic logic exp_ok(input logic [8:0] m);
    return !(m < 9'd250 || m > 9'd500);
  endfunction

  function automatic logic exp_test(input logic [1:0] t, input logic pl_n,
                                    input logic d, input logic fb, input logic fo);
    if (!pl_n) return 1'b0;
    case (t)
      2'd1:    return d;
      2'd2:    return fb;
      2'd3:    return fo;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_outs(input string req);
    check({req, " m"}, 32'(m_out), 32'(bm));
    check({req, " n"}, 32'(n_out), 32'(bn));
    check({req, " ok R9"}, 32'(m_ok), 32'(exp_ok(bm)));
  endtask

  task automatic check_test(input string req);
    check(req, 32'(test_out), 32'(exp_test(bt, pld_n, sdat, mfb_in, fout_in)));
  endtask

  // R1 R2 R11: parallel load and latch, then scramble pins
  task automatic par_load(input logic [8:0] m, input logic [2:0] n);
    pm_in = m; pn_in = n;
    wait_n(2);
    pld_n = 1'b0;
    wait_n(6);
    bm = m; bn = n;
    check_outs("R1 follow");
    check("R7 test low", 32'(test_out), 32'd0);
    pld_n = 1'b1;
    wait_n(6);
    pm_in = 9'($urandom); pn_in = 3'($urandom);
    wait_n(6);
    check_outs("R2 latched");
  endtask

  task automatic ser_bit(input logic b, input logic xparent);
    sdat = b;
    wait_n(3);
    sclk = 1'b1;
    bsh = {bsh[12:0], b};
    if (xparent) {bt, bn, bm} = bsh;
    wait_n(5);
    sclk = 1'b0;
    wait_n(3);
  endtask

  task automatic ser_word(input logic [13:0] w, input logic xparent);
    for (int i = 13; i >= 0; i--) begin
      ser_bit(w[i], xparent);
      if (xparent) check_outs("R5 transparent");
    end
  endtask

  task automatic ser_pulse();
    sld = 1'b1;
    wait_n(6);
    {bt, bn, bm} = bsh;
    check_outs("R4 load rise");
    sld = 1'b0;
    wait_n(6);
  endtask

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'h5eed);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R10 defaults
    check("R10 m", 32'(m_out), 32'd250);
    check("R10 n", 32'(n_out), 32'd0);
    check("R10 test", 32'(test_out), 32'd0);
    check("R10 ok", 32'(m_ok), 32'd1);
    check("R8 div_rst idle", 32'(div_rst), 32'd0);

    // R9 window edges
    par_load(9'd249, 3'd1);
    par_load(9'd250, 3'd2);
    par_load(9'd500, 3'd3);
    par_load(9'd501, 3'd7);
    par_load(9'd0,   3'd0);
    par_load(9'd511, 3'd5);

    // R3 word order: T=01 N=101 M=0x1A5
    ser_word({2'b01, 3'b101, 9'h1A5}, 1'b0);
    check("R3 no early", 32'(m_out), 32'(bm));
    ser_pulse();
    check("R3 field m", 32'(m_out), 32'h1A5);
    check("R3 field n", 32'(n_out), 32'd5);
    // R6 sdat source
    sdat = 1'b1; wait_n(5); check("R6 sel01 hi", 32'(test_out), 32'd1);
    sdat = 1'b0; wait_n(5); check("R6 sel01 lo", 32'(test_out), 32'd0);
    // R7 parallel mode forces low, and R11 parallel takes over
    sdat = 1'b1;
    pm_in = 9'd300; pn_in = 3'd4;
    wait_n(2);
    pld_n = 1'b0;
    wait_n(6);
    bm = 9'd300; bn = 3'd4;
    check("R7 forced low", 32'(test_out), 32'd0);
    check_outs("R11 takeover");
    // R3: shift clocks while parallel strobe is low are ignored
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; wait_n(5); sclk = 1'b0; wait_n(5);
    end
    pld_n = 1'b1;
    wait_n(6);
    sdat = 1'b0;
    wait_n(4);
    check("R6 T kept by parallel", 32'(test_out), 32'(exp_test(bt, 1'b1, sdat, mfb_in, fout_in)));
    ser_pulse();
    check("R3 gated m", 32'(m_out), 32'h1A5);

    // R4 freeze: shift after sld fall does not reach outputs
    ser_word({2'b10, 3'b011, 9'd260}, 1'b0);
    ser_pulse();
    ser_bit(1'b1, 1'b0);
    ser_bit(1'b0, 1'b0);
    check_outs("R4 frozen");
    ser_pulse();
    // R6 sources 10 / 11
    ser_word({2'b10, 3'b001, 9'd400}, 1'b0);
    ser_pulse();
    mfb_in = 1'b1; wait_n(1); check_test("R6 sel10 hi");
    mfb_in = 1'b0; wait_n(1); check_test("R6 sel10 lo");
    ser_word({2'b11, 3'b001, 9'd400}, 1'b0);
    ser_pulse();
    fout_in = 1'b1; wait_n(1); check_test("R6 sel11 hi");
    fout_in = 1'b0; wait_n(1); check_test("R6 sel11 lo");
    ser_word({2'b00, 3'b001, 9'd400}, 1'b0);
    ser_pulse();
    mfb_in = 1'b1; fout_in = 1'b1; sdat = 1'b1; wait_n(5);
    check_test("R6 sel00");

    // R8 master reset
    mrst = 1'b1;
    wait_n(5);
    check("R8 div_rst", 32'(div_rst), 32'd1);
    check_outs("R8 kept");
    check_test("R8 T kept");
    mrst = 1'b0;
    wait_n(5);
    check("R8 release", 32'(div_rst), 32'd0);

    // R5 transparent serial
    sld = 1'b1;
    wait_n(6);
    {bt, bn, bm} = bsh;
    ser_word({2'b01, 3'b110, 9'd333}, 1'b1);
    sld = 1'b0;
    wait_n(6);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        par_load(9'($urandom), 3'($urandom));
      end else if (op == 1) begin
        ser_word(14'($urandom), 1'b0);
        check_outs("R4 pre-load hold");
        ser_pulse();
      end else begin
        sld = 1'b1;
        wait_n(6);
        {bt, bn, bm} = bsh;
        check_outs("R5 sld high");
        for (int b = 0; b < 4; b++) begin
          ser_bit(1'($urandom), 1'b1);
          check_outs("R5 rand");
        end
        sld = 1'b0;
        wait_n(6);
      end
      mfb_in = 1'($urandom); fout_in = 1'($urandom); sdat = 1'($urandom);
      wait_n(5);
      check_test("R6 rand");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule